// File: doc/BRIEF.md
# Single Data Rate SCL/SDA Pin Driver

This block is the controller-side pin stage of a two-wire serial bus running at single data rate. An upstream sequencer hands it one bit at a time over a valid/ready command interface. Each command says whether the controller transmits or the target transmits. It also gives the bit value, whether SDA is driven push-pull or open-drain for that bit, and whether this receive bit is the one on which the target returns the line. The block produces SCL push-pull. Each bit is a low phase of programmable length followed by a high phase of programmable length. Both lengths are counted in system clock cycles, so one instance covers both slow symmetric timing and fast timing with a short high phase.

SDA is presented as a pad-enable and a pad-value pair. Open-drain bits can only pull the line low or release it. Push-pull bits drive both levels. All SDA drive changes are launched on the falling SCL edge, and the line is sampled on the rising edge. A single-cycle strobe then reports the sampled level. On a hand-back bit, the target lets go of SDA at the rising edge. The block then takes the line over on that same edge and drives the value it has just sampled, so the level stays the same for the whole high phase. If no command is waiting at the end of a high phase, the clock stops with SCL high and the SDA drive is held unchanged.

Top module: `sdr_pin_driver`

## Requirements
- R1: During and directly after reset, scl_o is 1, sda_oe is 0, bit_done is 0 and cmd_ready is 1.
- R2: After a command is accepted, scl_o is 0 for exactly max(lo_cnt,1) cycles starting the next cycle, and then 1 for max(hi_cnt,1) cycles.
- R3: A transmit command (cmd_rx=0) with cmd_pp=1 gives sda_oe=1 and sda_o=cmd_bit from the cycle after acceptance onward.
- R4: A transmit command with cmd_pp=0 gives sda_oe=1 with sda_o=0 when cmd_bit=0, and sda_oe=0 when cmd_bit=1, from the cycle after acceptance onward.
- R5: A receive command (cmd_rx=1) releases SDA (sda_oe=0) on the falling SCL edge, which is the cycle after acceptance.
- R6: sda_i is captured at the rising SCL edge. In the first cycle with scl_o high, bit_done is 1 for one cycle and rx_bit equals the captured level. rx_bit holds that level until the next capture.
- R7: On a receive command with cmd_handback=1, sda_oe=1 and sda_o equal the captured level from the first high cycle until the next command's falling edge. This holds through idle.
- R8: cmd_ready is 1 in idle and in the last cycle of a high phase. A command waiting at that point starts its low phase the next cycle, with no idle cycle in between.
- R9: A count of 0 in lo_cnt or hi_cnt gives a phase of one cycle.
- R10: While idle, changes on sda_i have no effect: bit_done stays 0, rx_bit, scl_o and the SDA drive are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cnt | input | CNT_W | SCL low phase length in clock cycles (0 treated as 1) |
| hi_cnt | input | CNT_W | SCL high phase length in clock cycles (0 treated as 1) |
| cmd_valid | input | 1 | A bit command is offered |
| cmd_ready | output | 1 | The block takes the command on this cycle |
| cmd_rx | input | 1 | 1: target drives the bit; 0: controller transmits |
| cmd_bit | input | 1 | Transmit value |
| cmd_pp | input | 1 | 1: push-pull drive; 0: open-drain drive |
| cmd_handback | input | 1 | Receive bit on which the target returns SDA |
| scl_o | output | 1 | Serial clock, push-pull |
| sda_oe | output | 1 | SDA pad drive enable |
| sda_o | output | 1 | SDA pad drive value |
| sda_i | input | 1 | SDA line level |
| bit_done | output | 1 | One-cycle strobe after each rising-edge sample |
| rx_bit | output | 1 | Last sampled SDA level |

## Verification
With both counts at one, the first high cycle of a bit is also its last. In that cycle the rising-edge capture, the bit_done strobe and the takeover of the next command all happen together, and on a hand-back bit the re-drive also starts there. The bench provokes this by holding cmd_valid high across two back-to-back bits and changing the command fields in the strobe cycle. It then checks that the strobe carries the first bit's sample. It also checks that the following cycle already shows SCL low with the second bit's drive, and that the second bit's sample comes one phase later.

// File: rtl/sdr_drv_pkg.sv
package sdr_drv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    typedef struct packed {
        logic rx;        // target owns the bit
        logic val;       // transmit value
        logic pp;        // push-pull when set
        logic handback;  // target returns SDA at the rising edge
    } bit_cmd_t;

    typedef struct packed {
        logic oe;
        logic o;
    } pad_t;

    // Pad state to apply at the falling edge that opens a bit.
    function automatic pad_t launch_drive(bit_cmd_t c);
        pad_t p;
        if (c.rx) begin
            p.oe = 1'b0;
            p.o  = 1'b0;
        end else if (c.pp) begin
            p.oe = 1'b1;
            p.o  = c.val;
        end else begin
            p.oe = ~c.val;
            p.o  = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/sdr_phase_timer.sv
module sdr_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] length,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] start_val;

    always_comb begin
        start_val = (length == ZERO) ? ZERO : (length - ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= ZERO;
        end else if (load) begin
            remain_q <= start_val;
        end else if (remain_q != ZERO) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign expire = (remain_q == ZERO);
endmodule

// File: rtl/sdr_bit_sampler.sv
module sdr_bit_sampler (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic line,
    output logic bit_done,
    output logic rx_bit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_done <= 1'b0;
            rx_bit   <= 1'b0;
        end else begin
            bit_done <= capture;
            if (capture) begin
                rx_bit <= line;
            end
        end
    end
endmodule

// File: rtl/sdr_sda_driver.sv
module sdr_sda_driver
    import sdr_drv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  bit_cmd_t cmd,
    input  logic     capture,
    input  logic     line,
    output logic     sda_oe,
    output logic     sda_o
);
    pad_t pad_q;
    logic redrive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_q     <= '0;
            redrive_q <= 1'b0;
        end else if (launch) begin
            pad_q     <= launch_drive(cmd);
            redrive_q <= cmd.rx & cmd.handback;
        end else if (capture && redrive_q) begin
            // take the line over on the same edge the target lets go
            pad_q.oe <= 1'b1;
            pad_q.o  <= line;
        end
    end

    assign sda_oe = pad_q.oe;
    assign sda_o  = pad_q.o;
endmodule

// File: rtl/sdr_pin_driver.sv
module sdr_pin_driver
    import sdr_drv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_rx,
    input  logic             cmd_bit,
    input  logic             cmd_pp,
    input  logic             cmd_handback,
    output logic             scl_o,
    output logic             sda_oe,
    output logic             sda_o,
    input  logic             sda_i,
    output logic             bit_done,
    output logic             rx_bit
);
    phase_t           phase_q;
    logic             scl_q;
    logic             expire;
    logic             accept;
    logic             rise;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    bit_cmd_t         cmd_s;

    assign cmd_s     = '{rx: cmd_rx, val: cmd_bit, pp: cmd_pp, handback: cmd_handback};
    assign cmd_ready = (phase_q == PH_IDLE) || ((phase_q == PH_HIGH) && expire);
    assign accept    = cmd_valid && cmd_ready;
    assign rise      = (phase_q == PH_LOW) && expire;
    assign tmr_load  = accept || rise;
    assign tmr_len   = accept ? lo_cnt : hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            scl_q   <= 1'b1;
        end else if (accept) begin
            phase_q <= PH_LOW;
            scl_q   <= 1'b0;
        end else if (rise) begin
            phase_q <= PH_HIGH;
            scl_q   <= 1'b1;
        end else if ((phase_q == PH_HIGH) && expire) begin
            phase_q <= PH_IDLE;
        end
    end

    assign scl_o = scl_q;

    sdr_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .length (tmr_len),
        .expire (expire)
    );

    sdr_sda_driver u_drv (
        .clk     (clk),
        .rst     (rst),
        .launch  (accept),
        .cmd     (cmd_s),
        .capture (rise),
        .line    (sda_i),
        .sda_oe  (sda_oe),
        .sda_o   (sda_o)
    );

    sdr_bit_sampler u_smp (
        .clk      (clk),
        .rst      (rst),
        .capture  (rise),
        .line     (sda_i),
        .bit_done (bit_done),
        .rx_bit   (rx_bit)
    );
endmodule

// File: rtl/sdr_pin_driver_chk.sv
module sdr_pin_driver_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic cmd_rx,
    input logic cmd_bit,
    input logic cmd_pp,
    input logic scl_o,
    input logic sda_oe,
    input logic sda_o,
    input logic bit_done
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (scl_o && !sda_oe && !bit_done && cmd_ready));

    // R3
    a_r3_pp_launch: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !cmd_rx && cmd_pp)
        |=> (sda_oe && (sda_o == $past(cmd_bit)) && !scl_o));

    // R4
    a_r4_od_release: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !cmd_rx && !cmd_pp && cmd_bit) |=> !sda_oe);

    // R5
    a_r5_rx_handoff: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_rx) |=> (!sda_oe && !scl_o));

    // R6
    a_r6_done_on_rise: assert property (@(posedge clk) disable iff (rst)
        bit_done |-> $rose(scl_o));

    // R8
    a_r8_fall_only_on_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_o) |-> $past(cmd_valid && cmd_ready));
endmodule

bind sdr_pin_driver sdr_pin_driver_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_rx    (cmd_rx),
    .cmd_bit   (cmd_bit),
    .cmd_pp    (cmd_pp),
    .scl_o     (scl_o),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o),
    .bit_done  (bit_done)
);

// File: tb/sdr_pin_driver_tb.sv
module sdr_pin_driver_tb;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] lo_cnt = 8'd2;
    logic [CNT_W-1:0] hi_cnt = 8'd2;
    logic cmd_valid = 1'b0, cmd_rx = 1'b0, cmd_bit = 1'b0, cmd_pp = 1'b0, cmd_handback = 1'b0;
    logic cmd_ready, scl_o, sda_oe, sda_o, bit_done, rx_bit;
    logic tgt_drive = 1'b0, tgt_val = 1'b1;
    logic sda_line;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // wired bus: controller pad wins where it drives, else target, else pull-up
    assign sda_line = sda_oe ? sda_o : (tgt_drive ? tgt_val : 1'b1);

    sdr_pin_driver #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rx(cmd_rx),
        .cmd_bit(cmd_bit), .cmd_pp(cmd_pp), .cmd_handback(cmd_handback),
        .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o), .sda_i(sda_line),
        .bit_done(bit_done), .rx_bit(rx_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // pad check: enable always, value only when enabled
    task automatic chk_pad(input string req, input bit eoe, input bit eo);
        chk(sda_oe == eoe, req, sda_oe, eoe);
        if (eoe) chk(sda_o == eo, req, sda_o, eo);
        if (tgt_drive && sda_oe) chk(sda_o == tgt_val, "R7 contention", sda_o, tgt_val);
    endtask

    // fields: rx, bit, pp, handback, lo[3:0], hi[3:0]
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {4'b0010, 4'd2, 4'd2},   // TX pp 0
        {4'b0110, 4'd3, 4'd1},   // TX pp 1, short high
        {4'b0000, 4'd2, 4'd3},   // TX od 0
        {4'b0100, 4'd1, 4'd2},   // TX od 1 released
        {4'b1000, 4'd2, 4'd2},   // RX target 0
        {4'b1100, 4'd2, 4'd2},   // RX target 1
        {4'b1001, 4'd3, 4'd3},   // RX handback, target 0
        {4'b1101, 4'd2, 4'd4},   // RX handback, target 1
        {4'b0110, 4'd0, 4'd0},   // TX pp 1, zero counts
        {4'b1001, 4'd0, 4'd2}    // RX handback 0, zero low count
    };

    task automatic run_bit(input logic [11:0] v);
        bit rx = v[11], b = v[10], pp = v[9], hb = v[8];
        int lo = (v[7:4] == 0) ? 1 : int'(v[7:4]);
        int hi = (v[3:0] == 0) ? 1 : int'(v[3:0]);
        bit eoe_lo, eo_lo, eoe_hi, eo_hi, exp_rx;
        bit tval;
        tval = b;
        if (rx) begin eoe_lo = 0; eo_lo = 0; end
        else if (pp) begin eoe_lo = 1; eo_lo = b; end
        else begin eoe_lo = ~b; eo_lo = 0; end
        exp_rx = b;
        eoe_hi = (rx && hb) ? 1'b1 : eoe_lo;
        eo_hi  = (rx && hb) ? tval : eo_lo;
        @(negedge clk);
        chk(cmd_ready == 1, "R8 ready idle", cmd_ready, 1);
        lo_cnt = {4'd0, v[7:4]}; hi_cnt = {4'd0, v[3:0]};
        cmd_rx = rx; cmd_bit = b; cmd_pp = pp; cmd_handback = hb; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        if (rx) begin tgt_drive = 1; tgt_val = tval; end
        for (int i = 0; i < lo; i++) begin
            chk(scl_o == 0, "R2/R9 low phase", scl_o, 0);
            chk_pad(rx ? "R5 rx release" : (pp ? "R3 pp drive" : "R4 od drive"), eoe_lo, eo_lo);
            @(negedge clk);
        end
        chk(scl_o == 1, "R2 rise", scl_o, 1);
        chk(bit_done == 1, "R6 done strobe", bit_done, 1);
        chk(rx_bit == exp_rx, "R6 sample", rx_bit, exp_rx);
        tgt_drive = 0;
        chk_pad(hb && rx ? "R7 redrive" : "R3/R4 hold", eoe_hi, eo_hi);
        for (int i = 1; i < hi; i++) begin
            @(negedge clk);
            chk(scl_o == 1 && bit_done == 0, "R2/R9 high phase", {scl_o, bit_done}, 2);
            chk_pad("R7 high hold", eoe_hi, eo_hi);
        end
        @(negedge clk);
        chk(scl_o == 1 && cmd_ready == 1, "R8 idle after bit", {scl_o, cmd_ready}, 3);
        chk_pad("R7 idle hold", eoe_hi, eo_hi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(scl_o == 1 && sda_oe == 0 && bit_done == 0 && cmd_ready == 1,
            "R1 reset state", {scl_o, sda_oe, bit_done, cmd_ready}, 9);
        rst = 0;
        @(negedge clk);
        chk(scl_o == 1 && sda_oe == 0 && cmd_ready == 1, "R1 after reset",
            {scl_o, sda_oe, cmd_ready}, 5);

        for (int k = 0; k < NV; k++) run_bit(VEC[k]);

        // R10: idle after an RX non-handback bit, wiggle the line
        run_bit({4'b1100, 4'd1, 4'd1});
        for (int i = 0; i < 4; i++) begin
            tgt_drive = 1; tgt_val = i[0];
            @(negedge clk);
            chk(bit_done == 0 && scl_o == 1 && sda_oe == 0 && rx_bit == 1,
                "R10 idle ignores sda_i", {bit_done, scl_o, sda_oe, rx_bit}, 5);
        end
        tgt_drive = 0;

        // R8: back-to-back with one-cycle phases; capture and next launch coincide
        lo_cnt = 8'd1; hi_cnt = 8'd1;
        cmd_rx = 0; cmd_pp = 1; cmd_bit = 1; cmd_handback = 0; cmd_valid = 1;
        @(negedge clk);   // accepted at last posedge
        chk(scl_o == 0 && cmd_ready == 0 && sda_oe == 1 && sda_o == 1, "R8 b2b low 1",
            {scl_o, cmd_ready, sda_oe, sda_o}, 3);
        @(negedge clk);
        chk(scl_o == 1 && bit_done == 1 && rx_bit == 1 && cmd_ready == 1, "R8 b2b high 1",
            {scl_o, bit_done, rx_bit, cmd_ready}, 15);
        cmd_bit = 0;
        @(negedge clk);
        cmd_valid = 0;
        chk(scl_o == 0 && sda_oe == 1 && sda_o == 0 && bit_done == 0, "R8 b2b low 2",
            {scl_o, sda_oe, sda_o, bit_done}, 4);
        @(negedge clk);
        chk(scl_o == 1 && bit_done == 1 && rx_bit == 0, "R8 b2b high 2",
            {scl_o, bit_done, rx_bit}, 6);
        @(negedge clk);
        chk(scl_o == 1 && bit_done == 0 && cmd_ready == 1, "R8 b2b idle",
            {scl_o, bit_done, cmd_ready}, 5);

        // R7: re-drive ends at the next falling edge, replaced by the new bit
        run_bit({4'b1101, 4'd2, 4'd2});
        lo_cnt = 8'd2; hi_cnt = 8'd2;
        cmd_rx = 0; cmd_pp = 0; cmd_bit = 1; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        chk(scl_o == 0 && sda_oe == 0, "R7 redrive ends at fall", {scl_o, sda_oe}, 0);
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule